// File: doc/BRIEF.md
# Floating-Point Coprocessor Status and Condition-Code Unit

This block holds the 32-bit control/status word of a floating-point coprocessor and everything that reads or changes it outside the arithmetic datapath. Eight condition codes sit at fixed, non-contiguous positions in the word. They are written by compare results coming from an external comparator, and they are tested by conditional branches. Software changes the status word through a masked control-write port. Software reads it, or a fixed implementation/revision constant, through a move-to-general-register port. The same port also forwards floating-point register values, sign-extended when the general registers are 64 bits wide.

Compare updates and control writes are registered and take effect at the next rising clock edge. Reads and branch decisions are combinational from the current status word. For a branch, the block only reports whether it is taken and whether the delay-slot instruction has to be squashed. Annulment, arithmetic and memory traffic stay in the surrounding pipeline.

Top module: `fpu_cc_unit`

## Requirements
- R1: Condition code 0 lives in status bit 23, and condition code k (k = 1..7) lives in status bit 24+k. Bit 24 is never changed by a compare.
- R2: A control write with `ctlWrIdx` = 31 replaces only the status bits set in 0x0083C078 (bits 3-6, 14-17 and 23). Every other bit keeps its value.
- R3: A control write to any index other than 31 leaves the status word unchanged, and `illegalWr` is high for exactly the one cycle after that write.
- R4: A control read (`rdFromCtl` = 1) with `rdIdx` below 16 returns 0x2E30 in the low word and zero in the upper word.
- R5: A control read with `rdIdx` of 16 or above returns the status word. With `mode64` = 1 the upper word is the sign of bit 31 repeated; with `mode64` = 0 the upper word is zero.
- R6: A register read (`rdFromCtl` = 0) returns `fprData`, with the upper word sign-extended when `mode64` = 1 and zero otherwise.
- R7: A read whose `rdDest` is 0 leaves `gprWrEn` low.
- R8: A compare (`cmpValid`) sets the condition code chosen by `cmpCc` (instruction bits 10:8) when `cmpResult` is 1 and clears it when `cmpResult` is 0. The change is visible from the next clock edge.
- R9: A compare with `cmpAlwaysFalse` = 1 clears the chosen condition code, whatever `cmpResult` is.
- R10: `brField` carries instruction bits 20:16: [4:2] picks the condition code, and [1:0] picks the variant (0 on false, 1 on true, 2 on false likely, 3 on true likely). `brTaken` is high when `brValid` is high and the code equals variant bit 0.
- R11: `brNullify` is high only for the likely variants (variant bit 1 set) when the branch is not taken.
- R12: When a compare and a status write occur in the same cycle, the write decides every masked bit, including condition code 0. A compare to any other code still takes effect.
- R13: Synchronous reset clears the status word to zero and drops `illegalWr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctlWrEn | input | 1 | Control-register write strobe |
| ctlWrIdx | input | 5 | Control-register index of the write |
| ctlWrData | input | 32 | Write value |
| illegalWr | output | 1 | One-cycle pulse after a write to an unsupported index |
| cmpValid | input | 1 | Compare result strobe |
| cmpCc | input | 3 | Target condition code (instruction bits 10:8) |
| cmpAlwaysFalse | input | 1 | Compare is the always-false form |
| cmpResult | input | 1 | Result from the external comparator |
| brValid | input | 1 | Branch evaluation request |
| brField | input | 5 | Branch instruction bits 20:16 |
| brTaken | output | 1 | Branch is taken |
| brNullify | output | 1 | Squash the delay slot (likely form, not taken) |
| rdValid | input | 1 | Move-to-general-register request |
| rdFromCtl | input | 1 | 1: control register source, 0: floating-point register source |
| rdIdx | input | 5 | Control-register index of the read |
| rdDest | input | 5 | Destination general register |
| fprData | input | 32 | Floating-point register value for register moves |
| mode64 | input | 1 | General registers are 64 bits wide |
| gprWrEn | output | 1 | General-register write enable |
| gprWrDest | output | 5 | General-register write address |
| gprWrData | output | 64 | General-register write value |

## Verification
Random cycles mix masked writes to index 31, writes to random other indices and compares to random codes, often in the same cycle. A reference model of the status word, read back after every cycle, tells the mask, the write-over-compare priority and the code-to-bit mapping apart. Directed cases set all ones through the mask, set code 7 to drive bit 31 for sign extension, and check bit 24 after a compare to code 0. They also read index 15 against index 16 and use destination zero. Every code is paired with all four branch variants against both code values, which separates the taken decision from the nullify decision.

// File: rtl/fpu_cc_pkg.sv
package fpu_cc_pkg;
  parameter int STATUS_W    = 32;
  parameter int NUM_CC      = 8;
  parameter int CC_SEL_W    = $clog2(NUM_CC);
  parameter int CTL_IDX_W   = 5;
  parameter int STATUS_IDX  = 31;
  parameter int RO_LIMIT    = 16;
  parameter int CC0_POS     = 23;
  parameter int CC_HI_BASE  = 24;
  parameter logic [STATUS_W-1:0] WR_MASK  = 32'h0083C078;
  parameter logic [STATUS_W-1:0] IMPL_REV = 32'h0000_2E30;

  // Bit position of condition code k inside the status word.
  function automatic int ccPos(input int k);
    return (k == 0) ? CC0_POS : CC_HI_BASE + k;
  endfunction

  typedef enum logic [1:0] {
    BR_ON_FALSE   = 2'd0,
    BR_ON_TRUE    = 2'd1,
    BR_FALSE_LIKE = 2'd2,
    BR_TRUE_LIKE  = 2'd3
  } brVariant_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 wrStatus;
    logic [STATUS_W-1:0]  wrData;
    logic                 cmpUpdate;
    logic [CC_SEL_W-1:0]  cmpCc;
    logic                 cmpValue;
  } ccStrobe_t;
endpackage

// File: rtl/fpu_cc_ctrl.sv
module fpu_cc_ctrl
  import fpu_cc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctlWrEn,
  input  logic [CTL_IDX_W-1:0] ctlWrIdx,
  input  logic [STATUS_W-1:0]  ctlWrData,
  input  logic                 cmpValid,
  input  logic [CC_SEL_W-1:0]  cmpCc,
  input  logic                 cmpAlwaysFalse,
  input  logic                 cmpResult,
  input  logic                 brValid,
  input  logic [CC_SEL_W+1:0]  brField,
  input  logic [NUM_CC-1:0]    ccVec,
  output ccStrobe_t            strobe,
  output logic                 illegalWr,
  output logic                 brTaken,
  output logic                 brNullify
);
  logic       hitStatus;
  logic       badWrite;
  logic       illegalQ;
  logic       selCc;
  brVariant_e variant;
  logic       condMet;

  assign hitStatus = (ctlWrIdx == CTL_IDX_W'(STATUS_IDX));
  assign badWrite  = ctlWrEn && !hitStatus;

  always_comb begin
    strobe.wrStatus  = ctlWrEn && hitStatus;
    strobe.wrData    = ctlWrData;
    strobe.cmpUpdate = cmpValid;
    strobe.cmpCc     = cmpCc;
    strobe.cmpValue  = cmpResult && !cmpAlwaysFalse;
  end

  always_ff @(posedge clk) begin
    if (rst) illegalQ <= 1'b0;
    else     illegalQ <= badWrite;
  end
  assign illegalWr = illegalQ;

  // Branch evaluation
  assign variant   = brVariant_e'(brField[1:0]);
  assign selCc     = ccVec[brField[CC_SEL_W+1:2]];
  assign condMet   = (selCc == variant[0]);
  assign brTaken   = brValid && condMet;
  assign brNullify = brValid && variant[1] && !condMet;

  a_r3_illegal_pulse: assert property (@(posedge clk) disable iff (rst)
    (ctlWrEn && ctlWrIdx != CTL_IDX_W'(STATUS_IDX)) |=> illegalWr);
  a_r3_no_false_pulse: assert property (@(posedge clk) disable iff (rst)
    !(ctlWrEn && ctlWrIdx != CTL_IDX_W'(STATUS_IDX)) |=> !illegalWr);
  a_r11_nullify_only_untaken: assert property (@(posedge clk) disable iff (rst)
    brNullify |-> (!brTaken && brField[1]));
  a_r10_idle_no_branch: assert property (@(posedge clk) disable iff (rst)
    !brValid |-> (!brTaken && !brNullify));
endmodule

// File: rtl/fpu_cc_datapath.sv
module fpu_cc_datapath
  import fpu_cc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ccStrobe_t            strobe,
  input  logic                 rdValid,
  input  logic                 rdFromCtl,
  input  logic [CTL_IDX_W-1:0] rdIdx,
  input  logic [4:0]           rdDest,
  input  logic [STATUS_W-1:0]  fprData,
  input  logic                 mode64,
  output logic [NUM_CC-1:0]    ccVec,
  output logic                 gprWrEn,
  output logic [4:0]           gprWrDest,
  output logic [2*STATUS_W-1:0] gprWrData
);
  logic [STATUS_W-1:0] statusQ;
  logic [STATUS_W-1:0] afterCmp;
  logic [STATUS_W-1:0] statusNxt;
  logic [STATUS_W-1:0] cmpMask;
  logic [STATUS_W-1:0] srcWord;

  // Per-code mask and code vector
  for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
    assign cmpMask[ccPos(k)] = (strobe.cmpCc == CC_SEL_W'(k));
    assign ccVec[k]          = statusQ[ccPos(k)];
  end
  for (genvar b = 0; b < STATUS_W; b++) begin : g_fill
    if (b != CC0_POS && !(b > CC_HI_BASE && b < CC_HI_BASE + NUM_CC)) begin : g_zero
      assign cmpMask[b] = 1'b0;
    end
  end

  always_comb begin
    afterCmp = statusQ;
    if (strobe.cmpUpdate)
      afterCmp = strobe.cmpValue ? (statusQ | cmpMask) : (statusQ & ~cmpMask);
    statusNxt = afterCmp;
    if (strobe.wrStatus)
      statusNxt = (afterCmp & ~WR_MASK) | (strobe.wrData & WR_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= statusNxt;
  end

  // Move to general register
  always_comb begin
    if (rdFromCtl)
      srcWord = (rdIdx < CTL_IDX_W'(RO_LIMIT)) ? IMPL_REV : statusQ;
    else
      srcWord = fprData;
    gprWrEn   = rdValid && (rdDest != 5'd0);
    gprWrDest = rdDest;
    if (mode64)
      gprWrData = {{STATUS_W{srcWord[STATUS_W-1]}}, srcWord};
    else
      gprWrData = {{STATUS_W{1'b0}}, srcWord};
  end

  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrStatus && !strobe.cmpUpdate) |=>
      ((statusQ & ~WR_MASK) == ($past(statusQ) & ~WR_MASK)));
  a_r8_cmp_lands: assert property (@(posedge clk) disable iff (rst)
    (strobe.cmpUpdate && !strobe.wrStatus) |=>
      ((statusQ & $past(cmpMask)) == ($past(strobe.cmpValue) ? $past(cmpMask) : '0)));
  a_r1_bit24_untouched: assert property (@(posedge clk) disable iff (rst)
    (strobe.cmpUpdate && !strobe.wrStatus) |=> $stable(statusQ[CC_HI_BASE]));
  a_r1_one_code: assert property (@(posedge clk) disable iff (rst)
    strobe.cmpUpdate |-> $onehot0(cmpMask));
  a_r7_no_zero_dest: assert property (@(posedge clk) disable iff (rst)
    gprWrEn |-> (gprWrDest != 5'd0));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.wrStatus && !strobe.cmpUpdate) |=> $stable(statusQ));
endmodule

// File: rtl/fpu_cc_unit.sv
module fpu_cc_unit
  import fpu_cc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctlWrEn,
  input  logic [4:0]  ctlWrIdx,
  input  logic [31:0] ctlWrData,
  output logic        illegalWr,
  input  logic        cmpValid,
  input  logic [2:0]  cmpCc,
  input  logic        cmpAlwaysFalse,
  input  logic        cmpResult,
  input  logic        brValid,
  input  logic [4:0]  brField,
  output logic        brTaken,
  output logic        brNullify,
  input  logic        rdValid,
  input  logic        rdFromCtl,
  input  logic [4:0]  rdIdx,
  input  logic [4:0]  rdDest,
  input  logic [31:0] fprData,
  input  logic        mode64,
  output logic        gprWrEn,
  output logic [4:0]  gprWrDest,
  output logic [63:0] gprWrData
);
  ccStrobe_t         strobe;
  logic [NUM_CC-1:0] ccVec;

  fpu_cc_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ctlWrEn(ctlWrEn), .ctlWrIdx(ctlWrIdx), .ctlWrData(ctlWrData),
    .cmpValid(cmpValid), .cmpCc(cmpCc), .cmpAlwaysFalse(cmpAlwaysFalse),
    .cmpResult(cmpResult), .brValid(brValid), .brField(brField),
    .ccVec(ccVec), .strobe(strobe), .illegalWr(illegalWr),
    .brTaken(brTaken), .brNullify(brNullify)
  );

  fpu_cc_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rdValid(rdValid), .rdFromCtl(rdFromCtl), .rdIdx(rdIdx),
    .rdDest(rdDest), .fprData(fprData), .mode64(mode64),
    .ccVec(ccVec), .gprWrEn(gprWrEn), .gprWrDest(gprWrDest),
    .gprWrData(gprWrData)
  );
endmodule

// File: tb/test_fpu_cc_unit.sv
module test_fpu_cc_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctlWrEn = 0; logic [4:0] ctlWrIdx = 0; logic [31:0] ctlWrData = 0;
  logic illegalWr;
  logic cmpValid = 0; logic [2:0] cmpCc = 0; logic cmpAlwaysFalse = 0; logic cmpResult = 0;
  logic brValid = 0; logic [4:0] brField = 0; logic brTaken, brNullify;
  logic rdValid = 0, rdFromCtl = 0, mode64 = 0;
  logic [4:0] rdIdx = 0, rdDest = 0; logic [31:0] fprData = 0;
  logic gprWrEn; logic [4:0] gprWrDest; logic [63:0] gprWrData;

  localparam logic [31:0] MASK = 32'h0083C078;
  int nChecks = 0, nFails = 0;
  logic [31:0] model = 0;
  logic expIllegal = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fpu_cc_unit i_fpu_cc_unit (.*);

  function automatic int posOf(input int k);
    return (k == 0) ? 23 : 24 + k;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: inputs already driven; model applies compare then write.
  task automatic step();
    logic [31:0] m;
    m = model;
    if (cmpValid) m[posOf(cmpCc)] = cmpResult && !cmpAlwaysFalse;
    if (ctlWrEn && ctlWrIdx == 5'd31) m = (m & ~MASK) | (ctlWrData & MASK);
    expIllegal = ctlWrEn && ctlWrIdx != 5'd31;
    @(posedge clk); @(negedge clk);
    model = m;
    ctlWrEn = 0; cmpValid = 0;
    chk("R3 illegal flag", {63'd0, illegalWr}, {63'd0, expIllegal});
  endtask

  task automatic readCheck(input string req, input logic fromCtl, input logic [4:0] idx,
                           input logic [4:0] dest, input logic m64, input logic [31:0] fpr);
    logic [31:0] w;
    logic [63:0] e;
    rdValid = 1; rdFromCtl = fromCtl; rdIdx = idx; rdDest = dest; mode64 = m64; fprData = fpr;
    #1;
    w = fromCtl ? ((idx < 16) ? 32'h2E30 : model) : fpr;
    e = m64 ? {{32{w[31]}}, w} : {32'd0, w};
    chk({req, " en"}, {63'd0, gprWrEn}, {63'd0, (dest != 0)});
    chk(req, gprWrData, e);
    rdValid = 0;
  endtask

  task automatic brCheck(input int cc, input int v);
    logic c, t;
    brValid = 1; brField = {3'(cc), 2'(v)};
    #1;
    c = model[posOf(cc)];
    t = (c == v[0]);
    chk("R10 taken", {63'd0, brTaken}, {63'd0, t});
    chk("R11 nullify", {63'd0, brNullify}, {63'd0, (v[1] && !t)});
    brValid = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R13 reset state
    readCheck("R13 reset status", 1, 5'd31, 5'd4, 1, 0);
    chk("R13 illegal low", {63'd0, illegalWr}, 64'd0);
    // R2 mask
    ctlWrEn = 1; ctlWrIdx = 31; ctlWrData = 32'hFFFF_FFFF; step();
    readCheck("R2 masked write", 1, 5'd31, 5'd1, 0, 0);
    chk("R2 exact value", {32'd0, model}, 64'h0083C078);
    // R8/R1 compare to code 7 then sign extension R5
    cmpValid = 1; cmpCc = 7; cmpResult = 1; step();
    readCheck("R5 sign-extended status", 1, 5'd16, 5'd2, 1, 0);
    cmpValid = 1; cmpCc = 0; cmpResult = 0; step();
    cmpValid = 1; cmpCc = 0; cmpResult = 1; step();
    readCheck("R1 cc0 bit23 bit24 clear", 1, 5'd31, 5'd3, 0, 0);
    cmpValid = 1; cmpCc = 3; cmpResult = 1; step();
    readCheck("R8 cc3 at bit27", 1, 5'd31, 5'd3, 0, 0);
    // R9 always-false
    cmpValid = 1; cmpCc = 3; cmpResult = 1; cmpAlwaysFalse = 1; step();
    cmpAlwaysFalse = 0;
    readCheck("R9 always-false clears", 1, 5'd31, 5'd3, 0, 0);
    // R3 unsupported index
    ctlWrEn = 1; ctlWrIdx = 5; ctlWrData = 32'h0; step();
    readCheck("R3 status unchanged", 1, 5'd31, 5'd3, 0, 0);
    @(negedge clk);
    chk("R3 pulse one cycle", {63'd0, illegalWr}, 64'd0);
    // R4
    readCheck("R4 low index constant", 1, 5'd15, 5'd9, 1, 0);
    readCheck("R4 index 0 constant", 1, 5'd0, 5'd9, 0, 0);
    // R7 / R6
    readCheck("R7 dest zero", 1, 5'd31, 5'd0, 1, 0);
    readCheck("R6 fpr sign-extended", 0, 5'd0, 5'd7, 1, 32'h8000_0001);
    readCheck("R6 fpr 32-bit", 0, 5'd0, 5'd7, 0, 32'h8000_0001);
    // R12 priority: write clears cc0 while compare sets cc0; compare to cc2 wins its bit
    cmpValid = 1; cmpCc = 0; cmpResult = 1; ctlWrEn = 1; ctlWrIdx = 31; ctlWrData = 0; step();
    readCheck("R12 write beats compare", 1, 5'd31, 5'd3, 0, 0);
    cmpValid = 1; cmpCc = 2; cmpResult = 1; ctlWrEn = 1; ctlWrIdx = 31; ctlWrData = MASK; step();
    readCheck("R12 other code kept", 1, 5'd31, 5'd3, 0, 0);
    // R10/R11 all codes, all variants
    for (int k = 0; k < 8; k++)
      for (int v = 0; v < 4; v++) brCheck(k, v);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      ctlWrEn = ($urandom % 2) == 0;
      ctlWrIdx = (($urandom % 5) < 3) ? 5'd31 : 5'($urandom);
      ctlWrData = $urandom;
      cmpValid = ($urandom % 2) == 0;
      cmpCc = 3'($urandom); cmpResult = 1'($urandom); cmpAlwaysFalse = (($urandom % 6) == 0);
      step();
      cmpAlwaysFalse = 0;
      readCheck("R2 R8 R12 random status", 1, 5'(16 + $urandom % 16), 5'($urandom), 1'($urandom), 0);
      brCheck(int'($urandom % 8), int'($urandom % 4));
    end
    // R13 reset again
    rst = 1; @(negedge clk); rst = 0; model = 0;
    readCheck("R13 cleared by reset", 1, 5'd31, 5'd1, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule